// File: doc/BRIEF.md
# Serial Priority Interrupt Chain

This block collects interrupt requests from a row of devices and settles which one the processor serves. Each device has a stage holding a pending flag. A device sets its flag with a request pulse. The OR of all pending flags is a single interrupt line to the processor. When the processor answers with an acknowledge, a grant token enters the first stage and moves down the row. The first stage that holds a pending flag keeps the token, blocks every stage below it, and places its own vector constant on a shared vector bus. Stage 0, nearest the processor, has the highest priority.

The acknowledge works as the strobe for the vector bus, and there is no back-pressure. The vector is valid in every cycle in which the acknowledge is high and a stage holds the grant. The processor must take it in that same cycle. The winning stage drops its flag on the next clock edge, so an acknowledge that stays high for another cycle serves the next pending stage. The wired-OR request line is modelled as a logical OR. The vector bus reads as zero when no stage drives it.

Top module: `prio_chain`

## Requirements
- R1: During reset and right after it, every pending flag is clear, `int_req` is 0, `vec_en` is all zeros and `vec_bus` is zero.
- R2: A high `dev_req[i]` at a clock edge sets pending flag i. `int_req` is 1 exactly when at least one pending flag is set.
- R3: While `int_ack` is 0, every bit of `prio_out` and `vec_en` is 0, whatever the flags hold.
- R4: A stage that receives the grant (priority-in 1) with its flag clear drives `prio_out[i]`=1 and `vec_en[i]`=0. Stage 0 takes `int_ack` as its priority-in, and stage i takes `prio_out[i-1]`.
- R5: A stage that receives the grant with its flag set drives `prio_out[i]`=0 and `vec_en[i]`=1. At most one bit of `vec_en` is ever set.
- R6: When `int_ack` is 1 and flags are pending, the pending stage with the lowest index is enabled, and no stage with a higher index is enabled.
- R7: `vec_bus` equals bits [i*8+7:i*8] of `vec_const` for the enabled stage i, and it is all zeros when no stage is enabled.
- R8: An enabled stage clears its flag on the next clock edge. The flags of all other stages keep their values.
- R9: If `dev_req[i]` is high at the same edge that would clear flag i, the flag stays set.
- R10: A pending flag that is not enabled and receives no request keeps its value. A request is never lost while the grant is withheld.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | NUM_STAGES | Request pulse per device, bit 0 has the highest priority |
| int_ack | input | 1 | Processor acknowledge; grant token into stage 0 |
| vec_const | input | NUM_STAGES*VEC_W | Vector constant per stage, stage i in bits [i*VEC_W +: VEC_W] |
| int_req | output | 1 | OR of all pending flags |
| vec_bus | output | VEC_W | Vector of the enabled stage, zero when none |
| vec_en | output | NUM_STAGES | Per-stage vector enable |
| prio_out | output | NUM_STAGES | Per-stage priority-out |

## Verification
The hardest cases to reach are the ones where the acknowledge stays high over several cycles while flags are pending at more than one stage. The grant must then move down the row one stage per cycle. A device that re-requests in the very cycle its flag is being cleared must keep its flag set. The stimulus raises requests at several stages first, then holds the acknowledge for a run of cycles, and pulses one device again exactly while it holds the grant. A long random phase then mixes requests and acknowledges, with a cycle-level reference model checking every output on every clock.

// File: rtl/prio_chain_pkg.sv
package prio_chain_pkg;
  localparam int DEF_STAGES = 4;
  localparam int DEF_VEC_W  = 8;

  // Stage decision derived from the grant token and the pending flag.
  typedef enum logic [1:0] {
    ST_BLOCKED = 2'b00,
    ST_PASS    = 2'b01,
    ST_CLAIM   = 2'b10
  } stage_dec_e;

  function automatic stage_dec_e decide(input logic pri_in, input logic pend);
    if (!pri_in)    return ST_BLOCKED;
    else if (!pend) return ST_PASS;
    else            return ST_CLAIM;
  endfunction
endpackage

// File: rtl/chain_stage.sv
module chain_stage
  import prio_chain_pkg::*;
#(
  parameter int VEC_W = DEF_VEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_req,
  input  logic             pri_in,
  input  logic [VEC_W-1:0] vec_in,
  output logic             pend,
  output logic             pri_out,
  output logic             en,
  output logic [VEC_W-1:0] vec_gated
);
  stage_dec_e dec;

  always_comb begin
    dec     = decide(pri_in, pend);
    pri_out = (dec == ST_PASS);
    en      = (dec == ST_CLAIM);
    vec_gated = en ? vec_in : '0;
  end

  // Set/reset flag: a new request dominates the clear on service.
  always_ff @(posedge clk) begin
    if (!rst_n)        pend <= 1'b0;
    else if (dev_req)  pend <= 1'b1;
    else if (en)       pend <= 1'b0;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |=> pend);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dev_req) |=> !pend);
  p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !dev_req) |=> $stable(pend));
endmodule

// File: rtl/vec_combiner.sv
module vec_combiner
  import prio_chain_pkg::*;
#(
  parameter int NUM_STAGES = DEF_STAGES,
  parameter int VEC_W      = DEF_VEC_W
) (
  input  logic [NUM_STAGES*VEC_W-1:0] gated,
  output logic [VEC_W-1:0]            bus
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < NUM_STAGES; i++) bus |= gated[i*VEC_W +: VEC_W];
  end
endmodule

// File: rtl/prio_chain.sv
module prio_chain
  import prio_chain_pkg::*;
#(
  parameter int NUM_STAGES = DEF_STAGES,
  parameter int VEC_W      = DEF_VEC_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_STAGES-1:0]       dev_req,
  input  logic                        int_ack,
  input  logic [NUM_STAGES*VEC_W-1:0] vec_const,
  output logic                        int_req,
  output logic [VEC_W-1:0]            vec_bus,
  output logic [NUM_STAGES-1:0]       vec_en,
  output logic [NUM_STAGES-1:0]       prio_out
);
  localparam int BUS_BITS = NUM_STAGES * VEC_W;

  logic [NUM_STAGES:0]   token;
  logic [NUM_STAGES-1:0] pend;
  logic [BUS_BITS-1:0]   gated;

  assign token[0] = int_ack;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    chain_stage #(.VEC_W(VEC_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .dev_req  (dev_req[g]),
      .pri_in   (token[g]),
      .vec_in   (vec_const[g*VEC_W +: VEC_W]),
      .pend     (pend[g]),
      .pri_out  (token[g+1]),
      .en       (vec_en[g]),
      .vec_gated(gated[g*VEC_W +: VEC_W])
    );
  end

  assign prio_out = token[NUM_STAGES:1];
  assign int_req  = |pend;

  vec_combiner #(.NUM_STAGES(NUM_STAGES), .VEC_W(VEC_W)) u_comb (
    .gated(gated),
    .bus  (vec_bus)
  );

  p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_en));
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !int_ack |-> (vec_en == '0 && prio_out == '0));
  p_served_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_req) |-> (vec_en != '0));
  p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_en == '0) |-> (vec_bus == '0));
endmodule

// File: tb/prio_chain_tb.sv
module prio_chain_tb;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] dev_req = '0;
  logic int_ack = 1'b0;
  logic [N*W-1:0] vec_const;
  logic int_req;
  logic [W-1:0] vec_bus;
  logic [N-1:0] vec_en, prio_out;

  int checks = 0, errors = 0;
  bit m_flag [N];
  int cyc = 0;

  always #4 clk = ~clk;

  prio_chain #(.NUM_STAGES(N), .VEC_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .int_ack(int_ack),
    .vec_const(vec_const), .int_req(int_req), .vec_bus(vec_bus),
    .vec_en(vec_en), .prio_out(prio_out));

  initial for (int i = 0; i < N; i++) vec_const[i*W +: W] = W'(8'h3C + 8'h25 * i);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: serve the lowest-index pending flag while acknowledged.
  task automatic compare(input string scen);
    int win = -1;
    logic [N-1:0] e_en = '0, e_po = '0;
    logic [W-1:0] e_bus = '0;
    bit any = 0;
    for (int i = 0; i < N; i++) any |= m_flag[i];
    if (int_ack) begin
      for (int i = 0; i < N; i++) begin
        if (m_flag[i]) begin win = i; break; end
        e_po[i] = 1'b1;
      end
    end
    if (win >= 0) begin
      e_en[win] = 1'b1;
      e_bus = vec_const[win*W +: W];
    end
    check(int_req == any, {scen, " R2 int_req"}, int'(int_req), int'(any));
    check(vec_en == e_en, {scen, " R5/R6 vec_en"}, int'(vec_en), int'(e_en));
    check(prio_out == e_po, {scen, " R4 prio_out"}, int'(prio_out), int'(e_po));
    check(vec_bus == e_bus, {scen, " R7 vec_bus"}, int'(vec_bus), int'(e_bus));
  endtask

  task automatic step(input logic [N-1:0] req, input logic ack, input string scen);
    logic [N-1:0] en_now;
    @(negedge clk);
    dev_req = req;
    int_ack = ack;
    #1;
    compare(scen);
    en_now = '0;
    for (int i = 0; i < N; i++) if (ack) begin
      if (m_flag[i]) begin en_now[i] = 1'b1; break; end
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (req[i]) m_flag[i] = 1'b1;
      else if (en_now[i]) m_flag[i] = 1'b0;
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_flag[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R1: outputs quiet under reset
    check(int_req == 1'b0, "R1 int_req in reset", int'(int_req), 0);
    check(vec_en == '0, "R1 vec_en in reset", int'(vec_en), 0);
    check(vec_bus == '0, "R1 vec_bus in reset", int'(vec_bus), 0);
    rst_n = 1'b1;
    step('0, 1'b0, "R1 after reset");
    step('0, 1'b1, "R4 grant passes empty chain");
    // R3: grant withheld with pending flags
    step(4'b1010, 1'b0, "R2 set flags 1,3");
    step('0, 1'b0, "R3 no ack");
    step('0, 1'b0, "R10 hold while not granted");
    // R6/R8: held acknowledge serves stage 1, then stage 3
    step('0, 1'b1, "R6 lowest pending wins");
    step('0, 1'b1, "R8 next stage served");
    step('0, 1'b1, "R8 chain empty");
    step('0, 1'b0, "R8 idle");
    // R9: re-request while being served
    step(4'b0001, 1'b0, "R2 set flag 0");
    step(4'b0001, 1'b1, "R9 set beats clear");
    step('0, 1'b0, "R9 flag kept");
    step('0, 1'b1, "R9 served again");
    step(4'b1111, 1'b0, "R2 all pending");
    for (int k = 0; k < 5; k++) step('0, 1'b1, "R6 drain in order");
    for (int k = 0; k < 400; k++)
      step(N'($urandom & $urandom), 1'($urandom), "R7 random mix");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule